// File: doc/BRIEF.md
# Depth-Stencil Pack/Unpack Stream Engine

This block moves pixels between one packed depth-stencil stream and two separate streams, a depth-word stream and a stencil-byte stream. It has two directions. In the merge direction it takes one depth word and one stencil byte per pixel and produces one packed pixel. In the split direction it takes one packed pixel and produces one depth word and one stencil byte. A two-bit format input picks the layout of the packed pixel. The choices are 24-bit depth in a 4-byte pixel, 32-bit float depth in an 8-byte pixel, and stencil alone, where single bytes pass through and no depth traffic occurs.

A job starts with a one-cycle `start` pulse while the block is idle. At that edge the block latches the direction, the format and the box dimensions (width, height, slices, each at least 1). It then transfers width × height × slices pixels. The column index moves fastest, then the row, then the slice, and the block shows the coordinates of the pixel currently being transferred. No port has a buffer. Each pixel is a single transfer that joins every stream taking part, so a stall on any one of them holds all of them. Address generation for the surfaces belongs to a neighbouring block. That block can use the coordinates shown here.

Top module: `zs_pack_engine`

## Requirements
- R1: Format 2'b00, merge: packed byte n (bits 8n+7:8n) equals depth byte n for n = 0..2. Byte 3 is the stencil byte. Bytes 4..7 are zero. Depth byte 3 is not used.
- R2: Format 2'b01, merge: packed bytes 0..3 are depth bytes 0..3. Byte 4 is the stencil byte. Bytes 5..7 are zero.
- R3: Format 2'b00, split: depth output bytes 0..2 come from packed bytes 0..2. Depth output byte 3 is zero and the depth byte enable is 4'b0111. The stencil output is packed byte 3. Packed bytes 4..7 are ignored.
- R4: Format 2'b01, split: the depth output is packed bytes 0..3 with byte enable 4'b1111. The stencil output is packed byte 4. Packed bytes 5..7 are ignored.
- R5: Formats 2'b10 and 2'b11 (stencil only): merge puts the stencil byte in packed byte 0 and drives the other bytes to zero. Split sends packed byte 0 to the stencil output. Neither direction ever asserts `dp_in_ready` or `dp_out_valid`.
- R6: A packed pixel moves only in a cycle where a stencil byte also moves and, except in stencil-only formats, a depth word moves too. Each pixel uses exactly one stencil byte.
- R7: If the packed sink or packed source, the stencil port or the depth port in use is not ready or not valid, every other port in the job sees no ready or valid in that cycle.
- R8: `pix_col`, `pix_row` and `pix_slice` start at 0. After each pixel transfer, the column steps first. When the column passes width-1 it wraps and the row steps. When the row passes height-1 it wraps and the slice steps.
- R9: `done` is high for exactly one cycle, the cycle after the width × height × slices-th transfer. `busy` falls at the same edge.
- R10: The block ignores `start` while `busy` is high. Changing the direction, format or box inputs during a job has no effect on that job. While idle, every valid and ready output is low.
- R11: After reset, `busy` and `done` are low and every valid and ready output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Starts a job when idle |
| dir_wr | input | 1 | 0 = merge into packed, 1 = split from packed |
| mode | input | 2 | Packed format: 00 24-bit, 01 32-bit float, 1x stencil only |
| box_w | input | DIM_W | Box width in pixels |
| box_h | input | DIM_W | Box height in rows |
| box_d | input | DIM_W | Box depth in slices |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse at job end |
| pix_col | output | DIM_W | Column of current pixel |
| pix_row | output | DIM_W | Row of current pixel |
| pix_slice | output | DIM_W | Slice of current pixel |
| dp_in_valid | input | 1 | Depth word offered (merge) |
| dp_in_ready | output | 1 | Depth word taken (merge) |
| dp_in_data | input | 32 | Depth word, byte n at bits 8n+7:8n |
| st_in_valid | input | 1 | Stencil byte offered (merge) |
| st_in_ready | output | 1 | Stencil byte taken (merge) |
| st_in_data | input | 8 | Stencil byte |
| pk_out_valid | output | 1 | Packed pixel offered (merge) |
| pk_out_ready | input | 1 | Packed pixel taken (merge) |
| pk_out_data | output | 64 | Packed pixel |
| pk_in_valid | input | 1 | Packed pixel offered (split) |
| pk_in_ready | output | 1 | Packed pixel taken (split) |
| pk_in_data | input | 64 | Packed pixel |
| dp_out_valid | output | 1 | Depth word offered (split) |
| dp_out_ready | input | 1 | Depth word taken (split) |
| dp_out_data | output | 32 | Depth word |
| dp_out_be | output | 4 | Byte enable of the depth word |
| st_out_valid | output | 1 | Stencil byte offered (split) |
| st_out_ready | input | 1 | Stencil byte taken (split) |
| st_out_data | output | 8 | Stencil byte |

## Verification
Some rules can be checked on every cycle, and the assertions do that. They check that a packed transfer always comes with the stencil transfer and, where depth is used, the depth transfer. They check that a stalled packed sink blocks the input readies, that stencil-only jobs never touch the depth ports, and that the padding bytes and byte enables of each format hold. They also check that the block is quiet while idle and that `done` lasts one cycle. Other behaviours depend on history, and only the bench's reference model can show them. These are the walk order and wrap points of the coordinates, the placement of `done` after exactly width × height × slices transfers, `start` being ignored in the middle of a job, and inputs changed during a job leaving the latched configuration alone.

// File: rtl/zs_pkg.sv
// Shared types and layout helpers for the depth-stencil stream engine.
// Assumes byte n of any word sits at bits 8n+7:8n.
package zs_pkg;

    localparam int PK_BYTES = 8;   // widest packed pixel
    localparam int DW_BYTES = 4;   // depth word width in bytes

    typedef enum logic [1:0] {
        ZS_D24    = 2'b00,
        ZS_F32    = 2'b01,
        ZS_S8     = 2'b10,
        ZS_S8_ALT = 2'b11
    } zs_fmt_e;

    // True when the format has no depth part.
    function automatic logic is_stencil_only(zs_fmt_e f);
        return f[1];
    endfunction

    // Number of depth bytes carried in a pixel.
    function automatic int depth_bytes(zs_fmt_e f);
        case (f)
            ZS_D24:  return 3;
            ZS_F32:  return 4;
            default: return 0;
        endcase
    endfunction

    // Byte lane of the packed pixel that holds the stencil value.
    function automatic int stencil_lane(zs_fmt_e f);
        case (f)
            ZS_D24:  return 3;
            ZS_F32:  return 4;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/zs_walk.sv
// Box walker: one counter per axis, column fastest, then row, then slice.
// Assumes every limit is at least 1. The counters are cleared on clear and
// advance on step; last is high while all axes sit at their final index.
module zs_walk #(
    parameter int DIM_W = 6,
    parameter int AXES  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear,
    input  logic                        step,
    input  logic [AXES-1:0][DIM_W-1:0]  lim,
    output logic [AXES-1:0][DIM_W-1:0]  pos,
    output logic                        last
);

    logic [AXES-1:0] at_end;
    logic [AXES-1:0] adv;

    generate
        for (genvar a = 0; a < AXES; a++) begin : g_axis
            logic [DIM_W-1:0] q;

            if (a == 0) begin : g_first
                assign adv[a] = step;
            end else begin : g_rest
                assign adv[a] = adv[a-1] & at_end[a-1];
            end

            assign at_end[a] = (q == lim[a] - DIM_W'(1));
            assign pos[a]    = q;

            // Axis counter: wraps to zero after its limit, carries upward.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (clear)
                    q <= '0;
                else if (adv[a])
                    q <= at_end[a] ? '0 : q + DIM_W'(1);
            end
        end
    endgenerate

    assign last = &at_end;

endmodule

// File: rtl/zs_merge.sv
// Merge path: builds one packed pixel from a depth word and a stencil byte.
// Purely combinational; unused lanes are zero.
module zs_merge
    import zs_pkg::*;
(
    input  zs_fmt_e                 fmt,
    input  logic [8*DW_BYTES-1:0]   dw,
    input  logic [7:0]              st,
    output logic [8*PK_BYTES-1:0]   pk
);

    // Place the used depth bytes, then drop the stencil into its lane.
    always_comb begin
        pk = '0;
        for (int b = 0; b < DW_BYTES; b++) begin
            if (b < depth_bytes(fmt))
                pk[8*b +: 8] = dw[8*b +: 8];
        end
        pk[8*stencil_lane(fmt) +: 8] = st;
    end

endmodule

// File: rtl/zs_split.sv
// Split path: pulls the depth bytes and stencil byte out of a packed pixel.
// Purely combinational; depth bytes not carried are zero and not enabled.
module zs_split
    import zs_pkg::*;
(
    input  zs_fmt_e                 fmt,
    input  logic [8*PK_BYTES-1:0]   pk,
    output logic [8*DW_BYTES-1:0]   dw,
    output logic [DW_BYTES-1:0]     be,
    output logic [7:0]              st
);

    // Copy the carried depth bytes with enables, fetch the stencil lane.
    always_comb begin
        dw = '0;
        be = '0;
        for (int b = 0; b < DW_BYTES; b++) begin
            if (b < depth_bytes(fmt)) begin
                dw[8*b +: 8] = pk[8*b +: 8];
                be[b]        = 1'b1;
            end
        end
        st = pk[8*stencil_lane(fmt) +: 8];
    end

endmodule

// File: rtl/zs_pack_engine.sv
// Depth-stencil pack/unpack stream engine (top).
// Latches the direction, format and box on start, then moves one pixel per
// joined transfer across the streams in use. There is no buffering: all
// handshakes of a pixel happen in the same cycle. Assumes box dims >= 1.
module zs_pack_engine
    import zs_pkg::*;
#(
    parameter int DIM_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dir_wr,
    input  logic [1:0]       mode,
    input  logic [DIM_W-1:0] box_w,
    input  logic [DIM_W-1:0] box_h,
    input  logic [DIM_W-1:0] box_d,
    output logic             busy,
    output logic             done,
    output logic [DIM_W-1:0] pix_col,
    output logic [DIM_W-1:0] pix_row,
    output logic [DIM_W-1:0] pix_slice,
    input  logic             dp_in_valid,
    output logic             dp_in_ready,
    input  logic [31:0]      dp_in_data,
    input  logic             st_in_valid,
    output logic             st_in_ready,
    input  logic [7:0]       st_in_data,
    output logic             pk_out_valid,
    input  logic             pk_out_ready,
    output logic [63:0]      pk_out_data,
    input  logic             pk_in_valid,
    output logic             pk_in_ready,
    input  logic [63:0]      pk_in_data,
    output logic             dp_out_valid,
    input  logic             dp_out_ready,
    output logic [31:0]      dp_out_data,
    output logic [3:0]       dp_out_be,
    output logic             st_out_valid,
    input  logic             st_out_ready,
    output logic [7:0]       st_out_data
);

    localparam int AXES = 3;

    logic                       busy_q;
    logic                       done_q;
    logic                       cfg_dir;
    zs_fmt_e                    cfg_fmt;
    logic [AXES-1:0][DIM_W-1:0] lim_q;
    logic [AXES-1:0][DIM_W-1:0] pos;
    logic                       last_pix;
    logic                       launch;
    logic                       s_only;
    logic                       rd_act;
    logic                       wr_act;
    logic                       dp_src_ok;
    logic                       dp_snk_ok;
    logic                       fire;

    assign launch = start & ~busy_q;

    // Configuration capture at the start of a job.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_dir <= 1'b0;
            cfg_fmt <= ZS_D24;
            lim_q   <= '0;
        end else if (launch) begin
            cfg_dir <= dir_wr;
            cfg_fmt <= zs_fmt_e'(mode);
            lim_q   <= {box_d, box_h, box_w};
        end
    end

    // Job state: busy from launch to last transfer, done one cycle after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= fire & last_pix;
            if (launch)
                busy_q <= 1'b1;
            else if (fire & last_pix)
                busy_q <= 1'b0;
        end
    end

    assign s_only    = is_stencil_only(cfg_fmt);
    assign rd_act    = busy_q & ~cfg_dir;
    assign wr_act    = busy_q & cfg_dir;
    assign dp_src_ok = s_only | dp_in_valid;
    assign dp_snk_ok = s_only | dp_out_ready;

    // Merge join: each port sees the others' readiness.
    assign pk_out_valid = rd_act & dp_src_ok & st_in_valid;
    assign st_in_ready  = rd_act & dp_src_ok & pk_out_ready;
    assign dp_in_ready  = rd_act & ~s_only & st_in_valid & pk_out_ready;

    // Split fork: each port sees the others' readiness.
    assign pk_in_ready  = wr_act & dp_snk_ok & st_out_ready;
    assign st_out_valid = wr_act & dp_snk_ok & pk_in_valid;
    assign dp_out_valid = wr_act & ~s_only & st_out_ready & pk_in_valid;

    assign fire = (pk_out_valid & pk_out_ready) | (pk_in_valid & pk_in_ready);

    zs_walk #(.DIM_W(DIM_W), .AXES(AXES)) u_walk (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (launch),
        .step  (fire),
        .lim   (lim_q),
        .pos   (pos),
        .last  (last_pix)
    );

    zs_merge u_merge (
        .fmt (cfg_fmt),
        .dw  (dp_in_data),
        .st  (st_in_data),
        .pk  (pk_out_data)
    );

    zs_split u_split (
        .fmt (cfg_fmt),
        .pk  (pk_in_data),
        .dw  (dp_out_data),
        .be  (dp_out_be),
        .st  (st_out_data)
    );

    assign busy      = busy_q;
    assign done      = done_q;
    assign pix_col   = pos[0];
    assign pix_row   = pos[1];
    assign pix_slice = pos[2];

endmodule

// File: rtl/zs_pack_engine_chk.sv
// Property checker for zs_pack_engine, attached by bind below.
// Observes the handshakes and the latched job state.
module zs_pack_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        cfg_dir,
    input logic [1:0]  cfg_mode,
    input logic        dp_in_valid,
    input logic        dp_in_ready,
    input logic        st_in_valid,
    input logic        st_in_ready,
    input logic        pk_out_valid,
    input logic        pk_out_ready,
    input logic [63:0] pk_out_data,
    input logic        pk_in_valid,
    input logic        pk_in_ready,
    input logic        dp_out_valid,
    input logic        dp_out_ready,
    input logic [31:0] dp_out_data,
    input logic [3:0]  dp_out_be,
    input logic        st_out_valid,
    input logic        st_out_ready
);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(pk_out_valid || st_in_ready || dp_in_ready ||
                    pk_in_ready || st_out_valid || dp_out_valid));

    p_merge_join_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_out_valid && pk_out_ready) |->
            (st_in_valid && st_in_ready &&
             (cfg_mode[1] || (dp_in_valid && dp_in_ready))));

    p_split_join_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_in_valid && pk_in_ready) |->
            (st_out_valid && st_out_ready &&
             (cfg_mode[1] || (dp_out_valid && dp_out_ready))));

    p_no_depth_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_mode[1]) |-> (!dp_in_ready && !dp_out_valid));

    p_d24_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_out_valid && cfg_mode == 2'b00) |->
            (dp_out_be == 4'b0111 && dp_out_data[31:24] == 8'h00));

    p_f32_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_out_valid && cfg_mode == 2'b01) |-> (dp_out_be == 4'b1111));

    p_d24_pad_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_out_valid && cfg_mode == 2'b00) |-> (pk_out_data[63:32] == 32'h0));

    p_f32_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_out_valid && cfg_mode == 2'b01) |-> (pk_out_data[63:40] == 24'h0));

    p_sink_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cfg_dir && !pk_out_ready) |-> (!st_in_ready && !dp_in_ready));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind zs_pack_engine zs_pack_engine_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy_q),
    .done         (done_q),
    .cfg_dir      (cfg_dir),
    .cfg_mode     (cfg_fmt),
    .dp_in_valid  (dp_in_valid),
    .dp_in_ready  (dp_in_ready),
    .st_in_valid  (st_in_valid),
    .st_in_ready  (st_in_ready),
    .pk_out_valid (pk_out_valid),
    .pk_out_ready (pk_out_ready),
    .pk_out_data  (pk_out_data),
    .pk_in_valid  (pk_in_valid),
    .pk_in_ready  (pk_in_ready),
    .dp_out_valid (dp_out_valid),
    .dp_out_ready (dp_out_ready),
    .dp_out_data  (dp_out_data),
    .dp_out_be    (dp_out_be),
    .st_out_valid (st_out_valid),
    .st_out_ready (st_out_ready)
);

// File: tb/test_zs_pack_engine.sv
// Bench: behavioural reference model compared against the engine each cycle.
module test_zs_pack_engine;

    localparam int CLK_PERIOD = 10;
    localparam int DIM_W      = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             dir_wr = 1'b0;
    logic [1:0]       mode = 2'b00;
    logic [DIM_W-1:0] box_w = 1, box_h = 1, box_d = 1;
    logic             busy, done;
    logic [DIM_W-1:0] pix_col, pix_row, pix_slice;
    logic             dp_in_valid = 0, st_in_valid = 0, pk_out_ready = 0;
    logic             pk_in_valid = 0, dp_out_ready = 0, st_out_ready = 0;
    logic             dp_in_ready, st_in_ready, pk_out_valid;
    logic             pk_in_ready, dp_out_valid, st_out_valid;
    logic [31:0]      dp_in_data = 0;
    logic [7:0]       st_in_data = 0;
    logic [63:0]      pk_in_data = 0;
    logic [63:0]      pk_out_data;
    logic [31:0]      dp_out_data;
    logic [3:0]       dp_out_be;
    logic [7:0]       st_out_data;

    zs_pack_engine #(.DIM_W(DIM_W)) i_zs_pack_engine (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // Reference model state
    bit m_busy = 0, m_done = 0, m_dir = 0;
    int m_fmt = 0, m_w = 1, m_h = 1, m_d = 1;
    int m_col = 0, m_row = 0, m_slc = 0;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic string fmt_tag(input int f, input bit split);
        if (f >= 2) return "R5";
        if (f == 0) return split ? "R3" : "R1";
        return split ? "R4" : "R2";
    endfunction

    // One cycle: inputs already driven; compare, advance model, wait.
    task automatic do_cycle();
        bit so, rd, wr, fire, last;
        bit e_pkov, e_stir, e_dpir, e_pkir, e_sov, e_dov;
        logic [63:0] e_pk;
        logic [31:0] e_dw;
        logic [3:0]  e_be;
        logic [7:0]  e_st;
        string t;
        #1;
        so = (m_fmt >= 2);
        rd = m_busy && !m_dir;
        wr = m_busy && m_dir;
        e_pkov = rd && st_in_valid && (so || dp_in_valid);
        e_stir = rd && pk_out_ready && (so || dp_in_valid);
        e_dpir = rd && !so && st_in_valid && pk_out_ready;
        e_pkir = wr && st_out_ready && (so || dp_out_ready);
        e_sov  = wr && pk_in_valid && (so || dp_out_ready);
        e_dov  = wr && !so && pk_in_valid && st_out_ready;
        chk("R6", "pk_out_valid", pk_out_valid, e_pkov);
        chk("R6", "st_out_valid", st_out_valid, e_sov);
        chk("R6", "dp_out_valid", dp_out_valid, e_dov);
        chk("R7", "st_in_ready", st_in_ready, e_stir);
        chk("R7", "dp_in_ready", dp_in_ready, e_dpir);
        chk("R7", "pk_in_ready", pk_in_ready, e_pkir);
        chk("R10", "busy", busy, m_busy);
        chk("R9", "done", done, m_done);
        chk("R8", "pix_col", pix_col, m_col);
        chk("R8", "pix_row", pix_row, m_row);
        chk("R8", "pix_slice", pix_slice, m_slc);
        case (m_fmt)
            0: begin
                e_pk = {32'h0, st_in_data, dp_in_data[23:0]};
                e_dw = {8'h0, pk_in_data[23:0]}; e_be = 4'b0111;
                e_st = pk_in_data[31:24];
            end
            1: begin
                e_pk = {24'h0, st_in_data, dp_in_data};
                e_dw = pk_in_data[31:0]; e_be = 4'b1111;
                e_st = pk_in_data[39:32];
            end
            default: begin
                e_pk = {56'h0, st_in_data};
                e_dw = 32'h0; e_be = 4'b0000;
                e_st = pk_in_data[7:0];
            end
        endcase
        if (e_pkov) chk(fmt_tag(m_fmt, 0), "pk_out_data", pk_out_data, e_pk);
        if (e_sov)  chk(fmt_tag(m_fmt, 1), "st_out_data", st_out_data, e_st);
        if (e_dov) begin
            t = fmt_tag(m_fmt, 1);
            chk(t, "dp_out_data", dp_out_data, e_dw);
            chk(t, "dp_out_be", dp_out_be, e_be);
        end
        fire = (e_pkov && pk_out_ready) || (pk_in_valid && e_pkir);
        last = (m_col == m_w-1) && (m_row == m_h-1) && (m_slc == m_d-1);
        m_done = m_busy && fire && last;
        if (!m_busy && start) begin
            m_busy = 1; m_dir = dir_wr; m_fmt = mode;
            m_w = box_w; m_h = box_h; m_d = box_d;
            m_col = 0; m_row = 0; m_slc = 0;
        end else if (m_busy && fire) begin
            if (last) m_busy = 0;
            if (m_col == m_w-1) begin
                m_col = 0;
                if (m_row == m_h-1) begin
                    m_row = 0;
                    m_slc = (m_slc == m_d-1) ? 0 : m_slc + 1;
                end else m_row++;
            end else m_col++;
        end
        @(negedge clk);
    endtask

    task automatic rand_stream(input int stall);
        dp_in_valid  = ($urandom % 100) >= stall;
        st_in_valid  = ($urandom % 100) >= stall;
        pk_out_ready = ($urandom % 100) >= stall;
        pk_in_valid  = ($urandom % 100) >= stall;
        dp_out_ready = ($urandom % 100) >= stall;
        st_out_ready = ($urandom % 100) >= stall;
        dp_in_data   = $urandom;
        st_in_data   = 8'($urandom);
        pk_in_data   = {$urandom, $urandom};
    endtask

    // Runs one job; mid-job the bench disturbs start, mode, dir and box (R10).
    task automatic run_job(input bit d, input int f, input int w, input int h,
                           input int s, input int stall);
        int guard = 0;
        start = 1; dir_wr = d; mode = 2'(f);
        box_w = DIM_W'(w); box_h = DIM_W'(h); box_d = DIM_W'(s);
        rand_stream(stall);
        do_cycle();
        while (m_busy && guard < 5000) begin
            start  = ($urandom % 6) == 0;
            mode   = 2'($urandom);
            dir_wr = 1'($urandom);
            box_w  = DIM_W'($urandom);
            rand_stream(stall);
            do_cycle();
            guard++;
        end
        start = 0;
        repeat (3) begin
            rand_stream(stall);
            do_cycle();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rand_stream(0);
        repeat (3) @(negedge clk);
        #1;
        chk("R11", "busy", busy, 0);
        chk("R11", "done", done, 0);
        chk("R11", "pk_out_valid", pk_out_valid, 0);
        chk("R11", "st_in_ready", st_in_ready, 0);
        chk("R11", "pk_in_ready", pk_in_ready, 0);
        chk("R11", "dp_out_valid", dp_out_valid, 0);
        @(negedge clk);
        rst_n = 1;
        run_job(0, 0, 2, 2, 1, 0);    // R1 full throughput
        run_job(0, 1, 3, 2, 2, 30);   // R2 with stalls, R8 slices
        run_job(0, 2, 4, 1, 1, 20);   // R5 merge
        run_job(1, 0, 2, 3, 1, 25);   // R3 split
        run_job(1, 1, 2, 2, 2, 35);   // R4 split
        run_job(1, 3, 3, 1, 2, 20);   // R5 split, alias code
        run_job(0, 0, 1, 1, 1, 50);   // R9 single pixel
        run_job(1, 0, 5, 2, 3, 60);   // R7 heavy back-pressure
        run_job(0, 1, 4, 3, 2, 10);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule